// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

This block is a half-duplex, byte-wide serial port driven by a shared serial clock. One data register serves both directions. A write loads the byte to send, and a read returns the byte most recently shifted in. A control register selects the clock speed, arms the end-of-transfer interrupt and starts a transfer in one direction. Each transfer moves eight bits, least significant bit first. Outgoing bits change on the falling edge of the serial clock. Incoming bits are sampled on its rising edge.

The serial clock comes from one of two places. Seven speed codes divide the system clock by 20, 40, 80, 160, 320, 640 or 1280, and the port drives the resulting clock out on a pin. The eighth code hands the clock over to an external source. That source is synchronised into the system clock domain and must run slower than the system clock divided by 20. When the eighth edge pair completes, the port raises a completion flag, clears the direction enable that started the transfer and, if the interrupt is armed, requests service. Any access to the data register clears the flag.

Top module: `ssp_top`

## Requirements
- R1: After reset the control register reads 0x07 (speed code 7, every flag and enable 0), irq is 0, txd is 1, sclkOut is 1 and sclkOe is 0.
- R2: Control register fields are: bit 7 completion flag (read only; writes to it are ignored), bit 6 interrupt enable, bit 5 receive enable, bit 4 transmit enable, bit 3 reads 0, bits 2..0 speed code. When idle, a control write updates the interrupt enable and the speed code.
- R3: Writing 1 to the transmit enable starts sending the data register, LSB first. txd takes the next bit on each falling edge of the serial clock.
- R4: Writing 1 to the receive enable starts a receive. rxd is sampled on each rising edge of the serial clock, LSB first, and a data register read then returns the assembled byte.
- R5: For speed codes 0 to 6 the serial clock period is 20 << code system clock cycles. sclkOe is 1, and the clock idles high while no transfer runs.
- R6: Speed code 7 sets sclkOe to 0 and holds sclkOut at 1. The transfer then advances only on the edges of sclkIn.
- R7: In internal-clock mode the completion flag is set, and the active enable cleared, at the clock edge 8 × (20 << code) cycles after the edge that registers the start write.
- R8: irq equals the completion flag ANDed with the interrupt enable.
- R9: Any read or write of the data register clears the completion flag.
- R10: A control write that sets both enables starts a transmit only. While a transfer runs, writes to the enables, the speed code and the data register are ignored, but the interrupt enable still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select: 0 control, 1 data |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears the flag on a data read) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irq | output | 1 | Completion interrupt request |
| sclkIn | input | 1 | External serial clock |
| sclkOut | output | 1 | Generated serial clock |
| sclkOe | output | 1 | Drive enable for sclkOut |
| txd | output | 1 | Serial transmit data |
| rxd | input | 1 | Serial receive data |

## Verification
A register write takes effect at the clock edge it straddles, and each internal-clock edge appears half a period later: after 10 << code cycles the serial clock falls and txd changes together with it. In internal mode the completion flag and irq rise exactly 8 × (20 << code) cycles after the start edge. In external mode the flag rises three cycles after the sclkIn edge, one cycle for each of the two synchroniser stages and the edge detector. The bench drives inputs and samples outputs on falling system clock edges, so each count is checked at one exact sample. It checks irq one sample before and at the due cycle, and it samples txd at the same sample where sclkOut is first seen low. In external mode it waits eight cycles after each sclkIn edge, which leaves margin over the three-cycle synchroniser delay.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [2:0] SPEED_EXT = 3'b111;
  localparam int BIT_DONE  = 7;
  localparam int BIT_IRQEN = 6;
  localparam int BIT_RXEN  = 5;
  localparam int BIT_TXEN  = 4;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic shiftIn;
  } dpStrobe_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int BASE_DIV    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic [2:0] speed,
  input  logic       sclkIn,
  output logic       fallEv,
  output logic       riseEv,
  output logic       sclkOut,
  output logic       sclkOe
);
  import ssp_pkg::*;

  localparam int BASE_HALF = BASE_DIV / 2;
  localparam int MAX_HALF  = BASE_HALF << 6;
  localparam int CNT_W     = $clog2(MAX_HALF);

  logic             extMode;
  logic [CNT_W-1:0] halfLim;
  logic [CNT_W-1:0] cnt;
  logic             sclkInt;
  logic             intToggle;
  logic [SYNC_STAGES-1:0] syncQ;
  logic             extPrev;
  logic             extLvl;

  assign extMode = (speed == SPEED_EXT);
  assign halfLim = CNT_W'((BASE_HALF << speed) - 1);

  // internal divider: toggles the serial clock every half period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      sclkInt <= 1'b1;
    end else if (!run || extMode) begin
      cnt     <= '0;
      sclkInt <= 1'b1;
    end else if (cnt == halfLim) begin
      cnt     <= '0;
      sclkInt <= ~sclkInt;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign intToggle = run && !extMode && (cnt == halfLim);

  // external clock synchroniser
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[g] <= 1'b1;
      else if (g == 0) syncQ[g] <= sclkIn;
      else syncQ[g] <= syncQ[(g > 0) ? g - 1 : 0];
    end
  end

  assign extLvl = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) extPrev <= 1'b1;
    else extPrev <= extLvl;
  end

  always_comb begin
    if (intToggle) begin
      fallEv = sclkInt;
      riseEv = !sclkInt;
    end else begin
      fallEv = run && extMode && !extLvl && extPrev;
      riseEv = run && extMode && extLvl && !extPrev;
    end
  end

  assign sclkOut = extMode ? 1'b1 : sclkInt;
  assign sclkOe  = !extMode;

  // R5: the generated clock returns high whenever no transfer runs
  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> sclkOut);

  // R6: in external mode no event without an edge seen on the synchronised input
  p_ext_needs_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (extMode && (fallEv || riseEv)) |-> (extLvl != extPrev));
endmodule

// File: rtl/ssp_ctrl.sv
module ssp_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              fallEv,
  input  logic              riseEv,
  output ssp_pkg::dpStrobe_t strobe,
  output logic [DATA_W-1:0] ctrlByte,
  output logic              busy,
  output logic [2:0]        speed,
  output logic              irq
);
  import ssp_pkg::*;

  localparam int BCNT_W = $clog2(DATA_W);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(DATA_W - 1);

  logic doneFlag;
  logic irqEn;
  logic txEn;
  logic rxEn;
  logic [BCNT_W-1:0] bitCnt;

  assign busy = txEn || rxEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      irqEn    <= 1'b0;
      txEn     <= 1'b0;
      rxEn     <= 1'b0;
      speed    <= SPEED_EXT;
      bitCnt   <= '0;
    end else begin
      if (dataWr || dataRd) doneFlag <= 1'b0;
      if (ctrlWr) begin
        irqEn <= wrData[BIT_IRQEN];
        if (!busy) begin
          speed <= wrData[2:0];
          if (wrData[BIT_TXEN]) txEn <= 1'b1;
          else if (wrData[BIT_RXEN]) rxEn <= 1'b1;
        end
      end
      if (busy && riseEv) begin
        if (bitCnt == LAST_BIT) begin
          bitCnt   <= '0;
          txEn     <= 1'b0;
          rxEn     <= 1'b0;
          doneFlag <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobe.load     = dataWr && !busy;
    strobe.shiftOut = fallEv && txEn;
    strobe.shiftIn  = riseEv && rxEn;
  end

  always_comb begin
    ctrlByte            = '0;
    ctrlByte[BIT_DONE]  = doneFlag;
    ctrlByte[BIT_IRQEN] = irqEn;
    ctrlByte[BIT_RXEN]  = rxEn;
    ctrlByte[BIT_TXEN]  = txEn;
    ctrlByte[2:0]       = speed;
  end

  assign irq = doneFlag && irqEn;

  // R10: one direction at a time
  p_half_duplex_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(txEn && rxEn));

  // R7: a transfer only ends by raising the completion flag
  p_end_sets_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneFlag);

  // R10: the speed code cannot move under a running transfer
  p_speed_locked_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(speed));
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ssp_pkg::dpStrobe_t strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rxd,
  output logic [DATA_W-1:0] shReg,
  output logic              txd
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      txd   <= 1'b1;
    end else if (strobe.load) begin
      shReg <= wrData;
    end else if (strobe.shiftOut) begin
      txd   <= shReg[0];
      shReg <= {1'b0, shReg[DATA_W-1:1]};
    end else if (strobe.shiftIn) begin
      shReg <= {rxd, shReg[DATA_W-1:1]};
    end
  end

  // R3: at most one register action per cycle
  p_one_action_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.shiftOut, strobe.shiftIn}));

  // R3: txd only moves on a falling serial edge of a transmit
  p_txd_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftOut |=> $stable(txd));
endmodule

// File: rtl/ssp_top.sv
module ssp_top #(
  parameter int DATA_W      = 8,
  parameter int BASE_DIV    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  input  logic              sclkIn,
  output logic              sclkOut,
  output logic              sclkOe,
  output logic              txd,
  input  logic              rxd
);
  import ssp_pkg::*;

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] ctrlByte;
  logic [DATA_W-1:0] shReg;
  logic              busy;
  logic [2:0]        speed;
  logic              fallEv;
  logic              riseEv;

  ssp_clkgen #(.BASE_DIV(BASE_DIV), .SYNC_STAGES(SYNC_STAGES)) uClk (
    .clk(clk), .rstN(rstN), .run(busy), .speed(speed), .sclkIn(sclkIn),
    .fallEv(fallEv), .riseEv(riseEv), .sclkOut(sclkOut), .sclkOe(sclkOe)
  );

  ssp_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .ctrlWr(wrEn && !regSel), .dataWr(wrEn && regSel), .dataRd(rdEn && regSel),
    .wrData(wrData), .fallEv(fallEv), .riseEv(riseEv),
    .strobe(strobe), .ctrlByte(ctrlByte), .busy(busy), .speed(speed), .irq(irq)
  );

  ssp_datapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rxd(rxd), .shReg(shReg), .txd(txd)
  );

  assign rdData = regSel ? shReg : ctrlByte;

  // R8: a request is never raised without the flag behind it
  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> rdData[BIT_DONE] || regSel);
endmodule

// File: tb/ssp_top_test.sv
`timescale 1ns/1ps
module ssp_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       irq;
  logic       sclkIn = 1'b1;
  logic       sclkOut;
  logic       sclkOe;
  logic       txd;
  logic       rxd = 1'b1;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  ssp_top uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .sclkIn(sclkIn),
    .sclkOut(sclkOut), .sclkOe(sclkOe), .txd(txd), .rxd(rxd)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic sel, output logic [7:0] v);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic expectReg(input logic sel, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    regRead(sel, v);
    check(v == exp, tag, v, exp);
  endtask

  // watches eight falling serial edges: checks txd, drives rxd, measures period
  task automatic runFalls(input logic [7:0] txExp, input logic [7:0] rxBits,
                          input bit chkTx, input string tag, output int period);
    int idx = 0;
    int cyc = 0;
    int firstAt = 0;
    logic prev = sclkOut;
    period = 0;
    while (idx < 8 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (prev && !sclkOut) begin
        if (chkTx) check(txd == txExp[idx], tag, txd, txExp[idx]);
        rxd = rxBits[idx];
        if (idx == 0) firstAt = cyc;
        if (idx == 1) period = cyc - firstAt;
        idx++;
      end
      prev = sclkOut;
    end
  endtask

  task automatic testReset();
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(txd == 1'b1, "R1 txd", txd, 1);
    check(sclkOut == 1'b1, "R1 sclkOut", sclkOut, 1);
    check(sclkOe == 1'b0, "R1 sclkOe", sclkOe, 0);
    expectReg(1'b0, 8'h07, "R1 control reset value");
  endtask

  task automatic testLayout();
    regWrite(1'b0, 8'hC3);
    expectReg(1'b0, 8'h43, "R2 flag not writable, irqEn and speed stored");
    check(irq == 1'b0, "R8 no irq without flag", irq, 0);
    check(sclkOe == 1'b1, "R5 internal mode drives clock", sclkOe, 1);
  endtask

  task automatic testTxTiming();
    logic prev;
    int idx = 0;
    logic [7:0] pat = 8'hA5;
    regWrite(1'b1, pat);
    regWrite(1'b0, 8'h50);
    prev = sclkOut;
    for (int c = 1; c <= 160; c++) begin
      @(negedge clk);
      if (prev && !sclkOut && idx < 8) begin
        check(txd == pat[idx], "R3 tx bit LSB first", txd, pat[idx]);
        idx++;
      end
      prev = sclkOut;
      if (c == 159) check(irq == 1'b0, "R7 flag not early", irq, 0);
      if (c == 160) check(irq == 1'b1, "R7 flag due at 8N cycles", irq, 1);
    end
    expectReg(1'b0, 8'hC0, "R7 enable cleared with flag set");
    expectReg(1'b1, 8'h00, "R3 register shifted empty");
    expectReg(1'b0, 8'h40, "R9 data read clears flag");
    check(irq == 1'b0, "R8 irq drops with flag", irq, 0);
  endtask

  task automatic testRx();
    int per;
    regWrite(1'b0, 8'h21);
    runFalls(8'h00, 8'h3C, 1'b0, "R4 rx", per);
    repeat (45) @(negedge clk);
    expectReg(1'b0, 8'h81, "R4 receive ends with flag, irq disabled");
    check(irq == 1'b0, "R8 masked irq", irq, 0);
    expectReg(1'b1, 8'h3C, "R4 received byte");
    expectReg(1'b0, 8'h01, "R9 flag cleared by data read");
  endtask

  task automatic testSpeeds();
    int per;
    for (int code = 0; code < 7; code++) begin
      regWrite(1'b1, 8'h5A);
      regWrite(1'b0, 8'h10 | code[7:0]);
      runFalls(8'h5A, 8'hFF, 1'b1, "R3 tx bits at speed", per);
      check(per == (20 << code), "R5 serial clock period", per, 20 << code);
      repeat ((20 << code) + 2) @(negedge clk);
      expectReg(1'b0, 8'h80 | code[7:0], "R7 flag at speed");
      regWrite(1'b1, 8'h00);
      expectReg(1'b0, code[7:0], "R9 data write clears flag");
    end
  endtask

  task automatic testHalfDuplex();
    int per;
    regWrite(1'b1, 8'h81);
    regWrite(1'b0, 8'h30);
    expectReg(1'b0, 8'h10, "R10 both enables give transmit only");
    regWrite(1'b0, 8'h61);
    expectReg(1'b0, 8'h50, "R10 busy write keeps enables and speed");
    regWrite(1'b1, 8'h7E);
    runFalls(8'h81, 8'hFF, 1'b1, "R10 data write ignored while busy", per);
    check(per == 20, "R10 speed unchanged while busy", per, 20);
    repeat (25) @(negedge clk);
    expectReg(1'b0, 8'hC0, "R10 transfer ends normally");
    check(irq == 1'b1, "R8 irq with flag and enable", irq, 1);
    regWrite(1'b1, 8'h00);
  endtask

  task automatic testExtTx();
    logic [7:0] pat = 8'h96;
    logic t0;
    regWrite(1'b1, pat);
    regWrite(1'b0, 8'h17);
    check(sclkOe == 1'b0, "R6 clock not driven", sclkOe, 0);
    check(sclkOut == 1'b1, "R6 clock output parked high", sclkOut, 1);
    t0 = txd;
    repeat (30) @(negedge clk);
    check(txd == t0, "R6 no progress without edges", txd, t0);
    expectReg(1'b0, 8'h17, "R6 still waiting for external clock");
    for (int i = 0; i < 8; i++) begin
      sclkIn = 1'b0;
      repeat (8) @(negedge clk);
      check(txd == pat[i], "R6 external clock tx bit", txd, pat[i]);
      sclkIn = 1'b1;
      repeat (8) @(negedge clk);
    end
    expectReg(1'b0, 8'h87, "R6 external transfer completes");
    regWrite(1'b1, 8'h00);
  endtask

  task automatic testExtRx();
    logic [7:0] pat = 8'h5A;
    regWrite(1'b0, 8'h27);
    for (int i = 0; i < 8; i++) begin
      sclkIn = 1'b0;
      rxd = pat[i];
      repeat (8) @(negedge clk);
      sclkIn = 1'b1;
      repeat (8) @(negedge clk);
    end
    expectReg(1'b0, 8'h87, "R6 external receive completes");
    expectReg(1'b1, pat, "R4 external receive byte");
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLayout();
    testTxTiming();
    testRx();
    testSpeeds();
    testHalfDuplex();
    testExtTx();
    testExtRx();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule